// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block orders the phases of one successive-approximation conversion. After each finished conversion it runs a fixed input acquisition made of a coarse settling phase and a fine settling phase. It then lowers its end-of-track flag and waits for a hold command. The hold can come from the block itself (loopback) or from the hold input. The hold input is taken up on a divide-by-four phase of the clock.

After a fixed settling prelude, the conversion decides one result bit every four clocks. The analog comparator is replaced by a comparison-result input. Each bit goes out on the serial data line with one serial clock pulse as soon as it is decided, most significant bit first. When the last bit is decided, the parallel result is loaded and the end-of-conversion flag drops. That flag is released either by a continuous independent-mode select or by a completed read strobe. Releasing it starts the next acquisition.

Top module: `sar_seq_top`

## Requirements
- R1: While rst_ni is low, eot_no and eoc_no are high, sclk_o and sdata_o are low and result_o is zero.
- R2: eot_no falls exactly 15 clock edges after eoc_no rises, and 15 edges after reset is released. This is 6 coarse cycles plus 9 fine cycles. eot_no and eoc_no are never low together.
- R3: With loopback_i high, eot_no is low for exactly one cycle and conversion starts on the next edge. hold_ni has no effect.
- R4: With loopback_i low, eot_no stays low until hold_ni is sampled low. eot_no then rises 1 to 4 edges later, on the edge where a free-running 2-bit phase counter (zero at reset) reads 3.
- R5: Conversion length, from the edge where eot_no rises to the edge where eoc_no falls, is 64 cycles for res_sel_i=0 (12 bits), 72 for 1 (14 bits) and 80 for 2 or 3 (16 bits). res_sel_i is sampled when conversion starts.
- R6: Each result bit appears on sdata_o during a one-cycle sclk_o pulse, most significant bit first, with pulses 4 cycles apart. Exactly one pulse is sent per bit.
- R7: A bit decides to 1 when cmp_high_i is low at the last edge of its 4-cycle slot, and to 0 otherwise. Slot k (k=0 for the most significant bit) ends 16+4k+4 edges after conversion start. result_o carries the result right-aligned in bits N-1..0, with the upper bits zero.
- R8: result_o changes only on the edge where eoc_no falls, and keeps its value until the next conversion ends.
- R9: In independent mode (addr_i=1, cs_ni=0, rd_ni=0 held), eoc_no is low for exactly 4 cycles.
- R10: In read mode, eoc_no stays low until a read (cs_ni=0, rd_ni=0, addr_i=0) ends. It rises on the 4th edge after the read strobe is released.
- R11: hold_ni pulses during a conversion change neither its length nor its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_ni | input | 1 | External hold command, active low |
| loopback_i | input | 1 | 1: end-of-track triggers hold internally |
| res_sel_i | input | 2 | Resolution: 0=12, 1=14, 2/3=16 bits |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| addr_i | input | 1 | 1: independent release, 0: read release |
| cmp_high_i | input | 1 | Comparator: trial value above input |
| eot_no | output | 1 | End of track, active low |
| eoc_no | output | 1 | End of conversion, active low |
| sclk_o | output | 1 | Serial bit clock pulse |
| sdata_o | output | 1 | Serial result bit |
| result_o | output | 16 | Parallel result, right-aligned |

## Verification
Conversions run at all three resolutions and at the out-of-range select code. Targets include alternating patterns, a lone LSB and all ones. These separate bit order, slot timing and right alignment, and show whether a stuck or swapped bit was decided correctly. Loopback and external-hold starts are mixed so that the one-cycle track window and the phase-aligned hold latency are both measured. Independent release and strobe release are both used to tell the two end-of-conversion paths apart. Hold pulses injected mid-conversion show whether the running conversion ignores them.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    ST_COARSE,
    ST_FINE,
    ST_TRACK,
    ST_CONV,
    ST_DONE
  } phase_e;
endpackage

// File: rtl/sar_rel_det.sv
module sar_rel_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rd_ni,
  input  logic addr_i,
  output logic rel_o
);
  logic rd_act, rd_q, indep;

  assign rd_act = !cs_ni && !rd_ni && !addr_i;
  assign indep  = !cs_ni && !rd_ni && addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_act;
  end

  // independent select is level, read releases on strobe end
  assign rel_o = indep || (rd_q && !rd_act);
endmodule

// File: rtl/sar_phase_ctl.sv
module sar_phase_ctl
  import sar_seq_pkg::*;
#(
  parameter int MAX_BITS   = 16,
  parameter int PRE_CYC    = 16,
  parameter int SLOT_CYC   = 4,
  parameter int COARSE_CYC = 6,
  parameter int FINE_CYC   = 9,
  parameter int REL_CYC    = 4,
  localparam int CNT_W  = $clog2(PRE_CYC + SLOT_CYC * MAX_BITS + 1),
  localparam int NB_W   = $clog2(MAX_BITS + 1),
  localparam int BIDX_W = $clog2(MAX_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_ni,
  input  logic              loopback_i,
  input  logic [1:0]        res_sel_i,
  input  logic              rel_i,
  output logic              conv_go_o,
  output logic              slot_start_o,
  output logic              decide_o,
  output logic              last_o,
  output logic [BIDX_W-1:0] pos_o,
  output logic              eot_no,
  output logic              eoc_no
);
  phase_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       ph_q;
  logic             hold_pend_q, rel_q;
  logic [NB_W-1:0]  nbits_q, nbits_sel;
  logic [CNT_W-1:0] conv_len, rel_off, slot_ph, slot_k;
  logic             in_bits, go;

  always_comb begin
    case (res_sel_i)
      2'd0:    nbits_sel = NB_W'(MAX_BITS - 4);
      2'd1:    nbits_sel = NB_W'(MAX_BITS - 2);
      default: nbits_sel = NB_W'(MAX_BITS);
    endcase
  end

  assign conv_len = CNT_W'(PRE_CYC) + CNT_W'(SLOT_CYC) * CNT_W'(nbits_q);
  assign in_bits  = (st_q == ST_CONV) && (cnt_q >= CNT_W'(PRE_CYC));
  assign rel_off  = cnt_q - CNT_W'(PRE_CYC);
  assign slot_ph  = rel_off % CNT_W'(SLOT_CYC);
  assign slot_k   = rel_off / CNT_W'(SLOT_CYC);

  // external hold is taken on divide-by-four phase 3
  assign go = loopback_i || ((hold_pend_q || !hold_ni) && (ph_q == 2'd3));

  assign conv_go_o    = (st_q == ST_TRACK) && go;
  assign slot_start_o = in_bits && (slot_ph == '0);
  assign decide_o     = in_bits && (slot_ph == CNT_W'(SLOT_CYC - 1));
  assign last_o       = (st_q == ST_CONV) && (cnt_q == conv_len - CNT_W'(1));
  assign pos_o        = BIDX_W'(CNT_W'(nbits_q) - CNT_W'(1) - slot_k);
  assign eot_no       = (st_q != ST_TRACK);
  assign eoc_no       = (st_q != ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_COARSE;
      cnt_q       <= '0;
      ph_q        <= '0;
      hold_pend_q <= 1'b0;
      rel_q       <= 1'b0;
      nbits_q     <= NB_W'(MAX_BITS);
    end else begin
      ph_q <= ph_q + 2'd1;
      case (st_q)
        ST_COARSE: begin
          if (cnt_q == CNT_W'(COARSE_CYC - 1)) begin
            st_q  <= ST_FINE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_FINE: begin
          if (cnt_q == CNT_W'(FINE_CYC - 1)) begin
            st_q        <= ST_TRACK;
            cnt_q       <= '0;
            hold_pend_q <= 1'b0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_TRACK: begin
          if (!hold_ni) hold_pend_q <= 1'b1;
          if (go) begin
            st_q        <= ST_CONV;
            cnt_q       <= '0;
            nbits_q     <= nbits_sel;
            hold_pend_q <= 1'b0;
          end
        end
        ST_CONV: begin
          if (last_o) begin
            st_q  <= ST_DONE;
            cnt_q <= '0;
            rel_q <= 1'b0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_DONE: begin
          if (rel_i || rel_q) begin
            rel_q <= 1'b1;
            if (cnt_q == CNT_W'(REL_CYC - 1)) begin
              st_q  <= ST_COARSE;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          st_q  <= ST_COARSE;
          cnt_q <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int MAX_BITS = 16,
  localparam int BIDX_W = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                conv_go_i,
  input  logic                slot_start_i,
  input  logic                decide_i,
  input  logic                last_i,
  input  logic [BIDX_W-1:0]   pos_i,
  input  logic                cmp_high_i,
  output logic                sclk_o,
  output logic                sdata_o,
  output logic [MAX_BITS-1:0] result_o
);
  logic [MAX_BITS-1:0] trial_q, trial_nxt;

  always_comb begin
    trial_nxt = trial_q;
    if (conv_go_i) trial_nxt = '0;
    else if (slot_start_i) trial_nxt[pos_i] = 1'b1;
    else if (decide_i && cmp_high_i) trial_nxt[pos_i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q  <= '0;
      sclk_o   <= 1'b0;
      sdata_o  <= 1'b0;
      result_o <= '0;
    end else begin
      trial_q <= trial_nxt;
      sclk_o  <= decide_i;
      if (decide_i) sdata_o <= !cmp_high_i;
      if (last_i) result_o <= trial_nxt;
    end
  end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int MAX_BITS   = 16,
  parameter int PRE_CYC    = 16,
  parameter int SLOT_CYC   = 4,
  parameter int COARSE_CYC = 6,
  parameter int FINE_CYC   = 9,
  parameter int REL_CYC    = 4,
  localparam int BIDX_W = $clog2(MAX_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hold_ni,
  input  logic                loopback_i,
  input  logic [1:0]          res_sel_i,
  input  logic                cs_ni,
  input  logic                rd_ni,
  input  logic                addr_i,
  input  logic                cmp_high_i,
  output logic                eot_no,
  output logic                eoc_no,
  output logic                sclk_o,
  output logic                sdata_o,
  output logic [MAX_BITS-1:0] result_o
);
  logic              rel, conv_go, slot_start, decide, last;
  logic [BIDX_W-1:0] pos;

  sar_rel_det u_rel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_ni (cs_ni),
    .rd_ni (rd_ni),
    .addr_i(addr_i),
    .rel_o (rel)
  );

  sar_phase_ctl #(
    .MAX_BITS  (MAX_BITS),
    .PRE_CYC   (PRE_CYC),
    .SLOT_CYC  (SLOT_CYC),
    .COARSE_CYC(COARSE_CYC),
    .FINE_CYC  (FINE_CYC),
    .REL_CYC   (REL_CYC)
  ) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_ni     (hold_ni),
    .loopback_i  (loopback_i),
    .res_sel_i   (res_sel_i),
    .rel_i       (rel),
    .conv_go_o   (conv_go),
    .slot_start_o(slot_start),
    .decide_o    (decide),
    .last_o      (last),
    .pos_o       (pos),
    .eot_no      (eot_no),
    .eoc_no      (eoc_no)
  );

  sar_bit_engine #(
    .MAX_BITS(MAX_BITS)
  ) u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_go_i   (conv_go),
    .slot_start_i(slot_start),
    .decide_i    (decide),
    .last_i      (last),
    .pos_i       (pos),
    .cmp_high_i  (cmp_high_i),
    .sclk_o      (sclk_o),
    .sdata_o     (sdata_o),
    .result_o    (result_o)
  );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int MAX_BITS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                loopback_i,
  input logic                eot_no,
  input logic                eoc_no,
  input logic                sclk_o,
  input logic [MAX_BITS-1:0] result_o
);
  // R2: track and conversion-end flags never overlap
  p_flags_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!eot_no && !eoc_no));

  // R3: loopback track window is one cycle
  p_loop_track_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(eot_no) && loopback_i) |=> eot_no);

  // R4: conversion never starts while end-of-conversion is low
  p_start_clean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eot_no) |-> eoc_no);

  // R6: serial clock pulses last one cycle
  p_sclk_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> !sclk_o);

  // R6: no serial activity during track
  p_sclk_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> eot_no);

  // R8: parallel result moves only when conversion ends
  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> $fell(eoc_no));
endmodule

bind sar_seq_top sar_seq_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .loopback_i(loopback_i),
  .eot_no    (eot_no),
  .eoc_no    (eoc_no),
  .sclk_o    (sclk_o),
  .result_o  (result_o)
);

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hold_ni = 1'b1;
  logic        loopback_i = 1'b1;
  logic [1:0]  res_sel_i = 2'd2;
  logic        cs_ni = 1'b1;
  logic        rd_ni = 1'b1;
  logic        addr_i = 1'b0;
  logic        cmp_high_i = 1'b0;
  logic        eot_no, eoc_no, sclk_o, sdata_o;
  logic [15:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_q[$];
  int cyc = 0;
  int last_pulse = 0;
  bit have_prev = 0;
  logic [15:0] prev_res = '0;

  always #4 clk_i = ~clk_i;

  sar_seq_top dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_ni   (hold_ni),
    .loopback_i(loopback_i),
    .res_sel_i (res_sel_i),
    .cs_ni     (cs_ni),
    .rd_ni     (rd_ni),
    .addr_i    (addr_i),
    .cmp_high_i(cmp_high_i),
    .eot_no    (eot_no),
    .eoc_no    (eoc_no),
    .sclk_o    (sclk_o),
    .sdata_o   (sdata_o),
    .result_o  (result_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pop expected serial bits, check pulse spacing
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && !eot_no) have_prev = 0;
    if (rst_ni && sclk_o) begin
      if (exp_q.size() == 0) check(1'b0, "R6 extra pulse", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        check(sdata_o == e, "R7 serial bit", int'(sdata_o), int'(e));
      end
      if (have_prev) check(cyc - last_pulse == 4, "R6 spacing", cyc - last_pulse, 4);
      last_pulse = cyc;
      have_prev  = 1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // driver: one full conversion; sel picks resolution
  task automatic run_conv(input logic [15:0] tgt, input logic [1:0] sel, input bit loop,
                          input bit indep, input bit glitch);
    int nb, len, c;
    nb  = (sel == 2'd0) ? 12 : (sel == 2'd1) ? 14 : 16;
    len = 16 + 4 * nb;
    loopback_i = loop;
    res_sel_i  = sel;
    addr_i     = indep;
    cs_ni      = !indep;
    rd_ni      = !indep;
    for (int k = 0; k < nb; k++) exp_q.push_back(tgt[nb-1-k]);
    // R2: acquisition length
    c = 0;
    do begin @(negedge clk_i); c++; end while (eot_no && c < 40);
    check(c == 15, "R2 acquisition", c, 15);
    if (loop) begin
      @(negedge clk_i);
      check(eot_no == 1'b1, "R3 one-cycle track", int'(eot_no), 1);
    end else begin
      repeat (8) @(negedge clk_i);
      check(eot_no == 1'b0, "R4 waits for hold", int'(eot_no), 0);
      hold_ni = 1'b0;
      c = 0;
      do begin @(negedge clk_i); c++; end while (!eot_no && c < 10);
      check(c >= 1 && c <= 4, "R4 hold latency", c, 4);
      hold_ni = 1'b1;
    end
    for (int j = 1; j <= len; j++) begin
      cmp_high_i = (j > 16) ? !tgt[nb-1-((j-17)/4)] : 1'b0;
      if (glitch) hold_ni = !(j >= 30 && j < 34);
      @(negedge clk_i);
      if (j == len - 1) begin
        check(eoc_no == 1'b1, "R5 not early", int'(eoc_no), 1);
        check(result_o == prev_res, "R8 holds", int'(result_o), int'(prev_res));
      end
    end
    hold_ni = 1'b1;
    check(eoc_no == 1'b0, "R5 length", int'(eoc_no), 0);
    check(result_o == tgt, "R7 R11 result", int'(result_o), int'(tgt));
    prev_res = result_o;
    if (indep) begin
      c = 0;
      do begin @(negedge clk_i); c++; end while (!eoc_no && c < 20);
      check(c == 4, "R9 independent release", c, 4);
    end else begin
      repeat (6) @(negedge clk_i);
      check(eoc_no == 1'b0, "R10 waits for read", int'(eoc_no), 0);
      cs_ni = 1'b0; rd_ni = 1'b0; addr_i = 1'b0;
      repeat (2) @(negedge clk_i);
      check(eoc_no == 1'b0, "R10 low during read", int'(eoc_no), 0);
      cs_ni = 1'b1; rd_ni = 1'b1;
      c = 0;
      do begin @(negedge clk_i); c++; end while (!eoc_no && c < 20);
      check(c == 4, "R10 read release", c, 4);
    end
    check(exp_q.size() == 0, "R6 all bits sent", exp_q.size(), 0);
    cs_ni = 1'b1; rd_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(eot_no == 1'b1 && eoc_no == 1'b1, "R1 flags", {eot_no, eoc_no}, 3);
    check(sclk_o == 1'b0 && sdata_o == 1'b0, "R1 serial idle", {sclk_o, sdata_o}, 0);
    check(result_o == 16'h0, "R1 result", int'(result_o), 0);
    rst_ni = 1'b1;
    run_conv(16'hA5C3, 2'd2, 1'b1, 1'b1, 1'b0);
    run_conv(16'h09F1, 2'd0, 1'b1, 1'b0, 1'b0);
    run_conv(16'h2AAA, 2'd1, 1'b0, 1'b1, 1'b1);
    run_conv(16'h0001, 2'd3, 1'b0, 1'b0, 1'b0);
    run_conv(16'h0FFF, 2'd0, 1'b1, 1'b1, 1'b1);
    run_conv(16'h1555, 2'd1, 1'b0, 1'b0, 1'b1);
    finish_run();
  end
endmodule